// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the 32-bit interrupt control register that sits beside a set of DMA channels. It holds a small group of plain control bits, a bus-error bit, one interrupt enable per channel, a global enable, one completion flag per channel and a summary bit that records that the request has already gone out. Software writes it over a simple register bus. Each channel's engine reports the end of a transfer with a one-cycle completion pulse.

The summary bit is recomputed after every update. It is set when the bus-error bit is set, or when the global enable is set and any channel flag is set. The interrupt controller sees a one-cycle request pulse only when the summary bit changes from clear to set. While the condition stays true, further completions or writes raise no further requests. Clearing the condition lets the next rise raise a new one.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data` reads 0x00000000 and `irq_o` is 0.
- R2: A write loads bits 0–5, bit 15 (bus error), bits 16–22 (channel enables, bit 16+n for channel n) and bit 23 (global enable) straight from `wr_data`. Bits 6–14 always read 0. Bit 31 of `wr_data` has no effect.
- R3: A write clears flag bit 24+n where `wr_data[24+n]` is 1 and leaves it unchanged where that bit is 0.
- R4: A `done_i[n]` pulse sets flag bit 24+n if enable bit 16+n is set, using the enable value after any write in the same cycle. With the enable clear, the pulse has no effect.
- R5: If a write clears flag n in the same cycle that `done_i[n]` sets it, the flag ends set.
- R6: After every update, bit 31 reads 1 exactly when bit 15 is set, or when bit 23 is set and any of bits 24–30 is set.
- R7: `irq_o` is a one-cycle pulse in the cycle after an update that takes bit 31 from 0 to 1. No pulse occurs while bit 31 stays 1.
- R8: Once bit 31 has returned to 0, the next 0-to-1 change of bit 31 raises a new pulse.
- R9: `rd_data` shows the whole register, bit 31 included, in the cycle after the update that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| done_i | input | NUM_CH | Per-channel completion pulses |
| rd_data | output | 32 | Current register value |
| irq_o | output | 1 | One-cycle request to the interrupt controller |

## Verification
The bench drives a write that clears a flag in the same cycle its channel completes. A design that applies the clear last would lose that completion. It sends completions to channels whose enable is set by that same write, and a design that reads the old enable would drop those flags. It keeps the condition true across many updates, where a level-driven request would fire again on each one. It then clears the condition and raises it once more, where a design whose sent bit sticks would never fire again. Attempts to write bit 31 would expose a sent bit that is taken from the bus instead of being recomputed.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned MISC_W   = 6;
  localparam int unsigned BERR_BIT = 15;
  localparam int unsigned EN_LSB   = 16;
  localparam int unsigned GEN_BIT  = 23;
  localparam int unsigned FLG_LSB  = 24;
  localparam int unsigned SENT_BIT = 31;
  localparam int unsigned MAX_CH   = GEN_BIT - EN_LSB;
endpackage

// File: rtl/dma_irq_flag_lane.sv
module dma_irq_flag_lane (
  input  logic flag_q,
  input  logic clr_req,
  input  logic en_new,
  input  logic done,
  output logic flag_d
);
  always_comb begin
    flag_d = (flag_q & ~clr_req) | (done & en_new);
  end
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              berr_d,
  input  logic              gen_d,
  input  logic [NUM_CH-1:0] flag_d,
  input  logic              sent_q,
  output logic              sent_d,
  output logic              rise_d
);
  always_comb begin
    sent_d = berr_d | (gen_d & (|flag_d));
    rise_d = sent_d & ~sent_q;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [31:0]       rd_data,
  output logic              irq_o
);
  logic [MISC_W-1:0] misc_q, misc_d;
  logic              berr_q, berr_d;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              gen_q, gen_d;
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic              sent_q, sent_d;
  logic              rise_d;
  logic              irq_q, irq_d;
  logic              upd;

  // Directly written fields
  always_comb begin
    upd    = wr_en | (|done_i);
    misc_d = wr_en ? wr_data[MISC_W-1:0]        : misc_q;
    berr_d = wr_en ? wr_data[BERR_BIT]          : berr_q;
    en_d   = wr_en ? wr_data[EN_LSB +: NUM_CH]  : en_q;
    gen_d  = wr_en ? wr_data[GEN_BIT]           : gen_q;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
    dma_irq_flag_lane u_lane (
      .flag_q  (flag_q[n]),
      .clr_req (wr_en & wr_data[FLG_LSB+n]),
      .en_new  (en_d[n]),
      .done    (done_i[n]),
      .flag_d  (flag_d[n])
    );
  end

  dma_irq_master #(.NUM_CH(NUM_CH)) u_master (
    .berr_d (berr_d),
    .gen_d  (gen_d),
    .flag_d (flag_d),
    .sent_q (sent_q),
    .sent_d (sent_d),
    .rise_d (rise_d)
  );

  always_comb begin
    irq_d = upd & rise_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q <= '0;
      berr_q <= 1'b0;
      en_q   <= '0;
      gen_q  <= 1'b0;
      flag_q <= '0;
      sent_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (upd) begin
        misc_q <= misc_d;
        berr_q <= berr_d;
        en_q   <= en_d;
        gen_q  <= gen_d;
        flag_q <= flag_d;
        sent_q <= sent_d;
      end
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[MISC_W-1:0]         = misc_q;
    rd_data[BERR_BIT]           = berr_q;
    rd_data[EN_LSB +: NUM_CH]   = en_q;
    rd_data[GEN_BIT]            = gen_q;
    rd_data[FLG_LSB +: NUM_CH]  = flag_q;
    rd_data[SENT_BIT]           = sent_q;
  end

  assign irq_o = irq_q;

  // R7
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sent_q && !$past(sent_q)));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R6
  sent_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q == (berr_q | (gen_q & (|flag_q))));
  // R8
  rerise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sent_q) && sent_q) |-> irq_o);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R4
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[n]) |-> ($past(done_i[n]) && en_q[n]));
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_data[FLG_LSB+n] && !done_i[n]) |-> !flag_q[n]);
  end
endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb;
  localparam int NCH = 7;
  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] done_i = '0;
  logic [31:0]    rd_data;
  logic           irq_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] model = '0;

  always #5 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .done_i(done_i), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic compare(input string tag, input logic [31:0] exp_rd, input logic exp_irq);
    vectors++;
    if (rd_data !== exp_rd || irq_o !== exp_irq) begin
      fails++;
      $display("FAIL %s: rd=%08h irq=%0b expected rd=%08h irq=%0b",
               tag, rd_data, irq_o, exp_rd, exp_irq);
    end
  endtask

  // One clock: drive at the falling edge, update reference, check after the rising edge
  task automatic step(input string tag, input logic wr, input logic [31:0] d,
                      input logic [NCH-1:0] dn);
    logic [31:0] nxt;
    logic [6:0]  fl;
    logic        ms, ex_irq;
    @(negedge clk);
    wr_en = wr; wr_data = d; done_i = dn;
    if (wr) nxt = (d & 32'h00FF803F) | (model & ~d & 32'h7F000000);
    else    nxt = model & 32'h7FFFFFFF;
    fl = nxt[30:24] | (7'(dn) & nxt[22:16]);
    nxt[30:24] = fl;
    ms = nxt[15] || (nxt[23] && (fl != 0));
    nxt[31] = ms;
    ex_irq = (wr || dn != 0) && ms && !model[31];
    if (!(wr || dn != 0)) nxt = model;
    model = nxt;
    @(posedge clk); #1;
    compare(tag, model, ex_irq);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset", 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle after reset", 1'b0, 32'h0, '0);
    // R2: direct fields, bit 31 ignored, bits 6-14 zero
    step("R2 write fields", 1'b1, 32'h807F_7FFF & 32'h807F7FFF, '0);
    step("R2 bit31 write ignored", 1'b1, 32'h8000_002A, '0);
    // R4: completion with enable clear then set in same write
    step("R4 no enable", 1'b0, 32'h0, 7'h7F);
    step("R4 enable same cycle", 1'b1, 32'h0005_0000, 7'h05);
    // R6/R7: global enable rises condition -> pulse
    step("R7 rise via global", 1'b1, 32'h0085_0000, '0);
    step("R7 pulse ends", 1'b0, 32'h0, '0);
    step("R7 no repeat", 1'b1, 32'h0085_0000, 7'h04);
    // R3: clear flag 0 only
    step("R3 w1c one flag", 1'b1, 32'h0185_0000, '0);
    // R5: clear and completion in same cycle
    step("R5 clear vs done", 1'b1, 32'h0485_0000, 7'h04);
    // R8: drop condition, raise again
    step("R8 drop", 1'b1, 32'h7F05_0000, '0);
    step("R8 rearm", 1'b1, 32'h0085_0000, 7'h01);
    step("R6 berr keeps sent", 1'b1, 32'h0100_8000, '0);
    step("R6 berr drop", 1'b1, 32'h7F00_0000, '0);
    step("R6 berr alone rise", 1'b1, 32'h0000_8000, '0);
    step("R9 idle hold", 1'b0, 32'h0, '0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [NCH-1:0] dn;
      d  = $urandom & 32'hFFFF_FFFF;
      if ($urandom % 4 != 0) d[15] = 1'b0;
      dn = 7'($urandom % 128) & ((i % 3 == 0) ? 7'h7F : 7'h00);
      step("R9 random", ($urandom % 2) == 1, d, dn);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule